// File: doc/BRIEF.md
# Word-Wide Octet Stuffer

This block is the transmit-side byte stuffer for a framed octet stream carried four bytes per word. A payload byte that equals the frame delimiter (0x7E) or the escape byte (0x7D) must not reach the line as it is. The block sends the escape byte 0x7D in its place, followed by the original byte with bit 5 inverted (XOR 0x20). Because of this, a four-byte input word can grow to as many as eight bytes. The block therefore keeps the expanded bytes in a small holding buffer and repacks them into dense 32-bit output words. It holds off the upstream side whenever more than one output word is pending.

Both sides use a valid/ready handshake with start-of-frame and end-of-frame markers. An input byte count selects how many of the low lanes of each input word are payload. Lane 0 (bits 7:0) is the earliest byte in time on both sides. When a frame ends, the block emits its remaining bytes as a final partial word with a byte count, and it accepts no new frame until that word has left. The opening and closing delimiters and the frame check sequence belong to neighbouring blocks.

Top module: `octet_stuffer_32`

## Requirements
- R1: A payload byte 0x7E leaves the block as the pair 0x7D, 0x5E in consecutive byte positions.
- R2: A payload byte 0x7D leaves the block as the pair 0x7D, 0x5D in consecutive byte positions.
- R3: Every other payload byte leaves unchanged. Byte order is preserved end to end, and lane 0 (bits 7:0) is the earliest byte of a word on both sides.
- R4: Every output word that does not carry the end-of-frame marker holds exactly four bytes (out_bytes_o = 4).
- R5: With out_ready_i held high, a frame of N full words that need no escaping is accepted in N consecutive cycles. A frame of N full words whose bytes are all 0x7E is accepted one word every two cycles, so it takes 2N-1 cycles.
- R6: The last output word of a frame carries out_eof_o. Its out_bytes_o (1 to 4) equals the number of remaining bytes, and its unused upper lanes are zero. No byte is lost, and no extra word follows.
- R7: out_sof_o is high on the first output word of each frame and low on every other word.
- R8: After the input word that carries the end-of-frame marker has been accepted, in_ready_o stays low until the last output word of that frame has been transferred.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o, out_data_o, out_bytes_o and out_eof_o hold their values into the next cycle.
- R10: After reset, in_ready_o is high and out_valid_o is low.
- R11: Input lanes at or above in_bytes_i (1 to 4) are ignored, even when they hold 0x7E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Block can take an input word |
| in_data_i | input | 32 | Input payload bytes, lane 0 in bits 7:0 |
| in_bytes_i | input | 3 | Number of valid low lanes, 1 to 4 |
| in_sof_i | input | 1 | Word is the first of a frame |
| in_eof_i | input | 1 | Word is the last of a frame |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output word |
| out_data_o | output | 32 | Stuffed bytes, lane 0 in bits 7:0 |
| out_bytes_o | output | 3 | Valid low lanes of the output word |
| out_sof_o | output | 1 | First output word of a frame |
| out_eof_o | output | 1 | Last output word of a frame |

## Verification
The holding buffer is the only store of byte positions. If its fill count or its shift is wrong, one byte shifts, repeats or is lost, and that shows in the very next output word as a byte mismatch against a byte-queue model. Errors in the pending-frame flags appear at the frame edges. A wrong end flag shows on the last word of the frame as a misplaced out_eof_o or a wrong out_bytes_o, or as in_ready_o rising while that word still waits. A wrong start flag shows as out_sof_o on a word that is not the first of its frame. A backpressure decision that is off by one cycle changes the acceptance cycle counts of the plain and all-0x7E frames, and with out_ready_i stalled at random it overruns the buffer.

// File: rtl/stuff_pkg.sv
package stuff_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  FLAG_CHAR = 8'h7E;
  localparam logic [7:0]  ESC_CHAR  = 8'h7D;
  localparam logic [7:0]  FLIP_MASK = 8'h20;

  function automatic logic needs_escape(input logic [7:0] b);
    return (b == FLAG_CHAR) || (b == ESC_CHAR);
  endfunction
endpackage

// File: rtl/stuff_expand.sv
module stuff_expand import stuff_pkg::*; #(
  parameter  int unsigned LANES = 4,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned EW    = $clog2(2 * LANES + 1)
) (
  input  logic [DW-1:0]   data_i,
  input  logic [CW-1:0]   bytes_i,
  output logic [2*DW-1:0] exp_data_o,
  output logic [EW-1:0]   exp_cnt_o
);
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_esc;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g]  = CW'(g) < bytes_i;
    assign lane_esc[g] = lane_en[g] && needs_escape(data_i[g*BYTE_W +: BYTE_W]);
  end

  // compact lanes, opening a slot after each escaped byte
  always_comb begin
    int pos;
    pos        = 0;
    exp_data_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) begin
        if (lane_esc[i]) begin
          exp_data_o[pos*BYTE_W +: BYTE_W]     = ESC_CHAR;
          exp_data_o[(pos+1)*BYTE_W +: BYTE_W] = data_i[i*BYTE_W +: BYTE_W] ^ FLIP_MASK;
          pos += 2;
        end else begin
          exp_data_o[pos*BYTE_W +: BYTE_W] = data_i[i*BYTE_W +: BYTE_W];
          pos += 1;
        end
      end
    end
    exp_cnt_o = EW'(pos);
  end
endmodule

// File: rtl/stuff_hold_buf.sv
module stuff_hold_buf import stuff_pkg::*; #(
  parameter  int unsigned LANES = 4,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned CAP   = 3 * LANES,
  localparam int unsigned BW    = $clog2(CAP + 1),
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned EW    = $clog2(2 * LANES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [2*DW-1:0] push_data_i,
  input  logic [EW-1:0]   push_cnt_i,
  input  logic [CW-1:0]   pop_cnt_i,
  output logic [DW-1:0]   head_o,
  output logic [BW-1:0]   cnt_o
);
  logic [BYTE_W-1:0] byte_q [CAP];
  logic [BYTE_W-1:0] byte_d [CAP];
  logic [BW-1:0]     cnt_q, cnt_d;

  // shift out popped bytes, append pushed bytes behind the survivors
  always_comb begin
    int pc, base, src, k;
    pc   = int'(pop_cnt_i);
    base = int'(cnt_q) - pc;
    for (int j = 0; j < CAP; j++) begin
      src       = j + pc;
      k         = j - base;
      byte_d[j] = '0;
      if (src < int'(cnt_q)) begin
        byte_d[j] = byte_q[src];
      end else if (push_i && k >= 0 && k < int'(push_cnt_i)) begin
        byte_d[j] = push_data_i[k*BYTE_W +: BYTE_W];
      end
    end
    cnt_d = BW'(base + (push_i ? int'(push_cnt_i) : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int j = 0; j < CAP; j++) byte_q[j] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int j = 0; j < CAP; j++) byte_q[j] <= byte_d[j];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign head_o[g*BYTE_W +: BYTE_W] = byte_q[g];
  end
  assign cnt_o = cnt_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BW'(CAP));
  // R6
  pop_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    BW'(pop_cnt_i) <= cnt_q);
endmodule

// File: rtl/stuff_frame_ctl.sv
module stuff_frame_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_fire_i,
  input  logic in_sof_i,
  input  logic in_eof_i,
  input  logic out_fire_i,
  input  logic out_last_i,
  output logic sof_pend_o,
  output logic eof_pend_o
);
  logic sof_q, eof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      if (in_fire_i && in_sof_i)      sof_q <= 1'b1;
      else if (out_fire_i)            sof_q <= 1'b0;
      if (in_fire_i && in_eof_i)      eof_q <= 1'b1;
      else if (out_fire_i && out_last_i) eof_q <= 1'b0;
    end
  end

  assign sof_pend_o = sof_q;
  assign eof_pend_o = eof_q;

  // R8
  eof_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |-> !in_fire_i);
  // R7
  sof_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sof_q) |-> $past(in_fire_i && in_sof_i));
endmodule

// File: rtl/octet_stuffer_32.sv
module octet_stuffer_32 import stuff_pkg::*; #(
  parameter  int unsigned LANES = 4,
  localparam int unsigned DW    = LANES * BYTE_W,
  localparam int unsigned CAP   = 3 * LANES,
  localparam int unsigned BW    = $clog2(CAP + 1),
  localparam int unsigned CW    = $clog2(LANES + 1),
  localparam int unsigned EW    = $clog2(2 * LANES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic [CW-1:0] in_bytes_i,
  input  logic          in_sof_i,
  input  logic          in_eof_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic [CW-1:0] out_bytes_o,
  output logic          out_sof_o,
  output logic          out_eof_o
);
  logic [2*DW-1:0] exp_data;
  logic [EW-1:0]   exp_cnt;
  logic [BW-1:0]   cnt;
  logic [DW-1:0]   head;
  logic [CW-1:0]   pop_cnt;
  logic            sof_pend, eof_pend, out_last, push, pop;

  stuff_expand #(.LANES(LANES)) u_expand (
    .data_i     (in_data_i),
    .bytes_i    (in_bytes_i),
    .exp_data_o (exp_data),
    .exp_cnt_o  (exp_cnt)
  );

  stuff_hold_buf #(.LANES(LANES)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (exp_data),
    .push_cnt_i  (exp_cnt),
    .pop_cnt_i   (pop_cnt),
    .head_o      (head),
    .cnt_o       (cnt)
  );

  stuff_frame_ctl u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_fire_i  (push),
    .in_sof_i   (in_sof_i),
    .in_eof_i   (in_eof_i),
    .out_fire_i (pop),
    .out_last_i (out_last),
    .sof_pend_o (sof_pend),
    .eof_pend_o (eof_pend)
  );

  // ready only from state: room for a full doubled word without counting a pop
  assign in_ready_o  = !eof_pend && (cnt <= BW'(LANES));
  assign push        = in_valid_i && in_ready_o;
  assign out_last    = eof_pend && (cnt <= BW'(LANES));
  assign out_valid_o = (cnt >= BW'(LANES)) || (eof_pend && (cnt != '0));
  assign out_bytes_o = out_last ? CW'(cnt) : CW'(LANES);
  assign out_data_o  = head;
  assign out_sof_o   = out_valid_o && sof_pend;
  assign out_eof_o   = out_valid_o && out_last;
  assign pop         = out_valid_o && out_ready_i;
  assign pop_cnt     = pop ? out_bytes_o : '0;

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_bytes_o) && $stable(out_eof_o)));
  // R5
  backpress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && (exp_cnt > EW'(LANES))) |=> !in_ready_o);
  // R3
  expand_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (exp_cnt >= EW'(in_bytes_i)) && (exp_cnt <= EW'(2 * in_bytes_i)));
  // R6
  last_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_bytes_o != '0) && (out_bytes_o <= CW'(LANES)));
  // R6
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eof_o |-> ((out_data_o >> (int'(out_bytes_o) * BYTE_W)) == '0));
endmodule

// File: tb/octet_stuffer_32_tb.sv
module octet_stuffer_32_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_bytes = 3'd4;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;

  always #5 clk = ~clk;

  octet_stuffer_32 u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_bytes_i(in_bytes), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_bytes_o(out_bytes), .out_sof_o(out_sof), .out_eof_o(out_eof)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_b [0:8191];
  string      exp_tag [0:8191];
  int wr_p = 0, rd_p = 0;
  int fr_start [0:255];
  int fr_end   [0:255];
  int fr_wr = 0, fr_rd = 0;
  logic [7:0] src_b [0:255];
  int ready_mode = 0;
  logic [15:0] rdy_lfsr = 16'hACE1;
  logic [15:0] dat_lfsr = 16'h1D2B;
  int acc_cyc;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void model_byte(input logic [7:0] b);
    if (b == 8'h7E) begin
      exp_b[wr_p] = 8'h7D; exp_tag[wr_p] = "R1";
      exp_b[wr_p+1] = 8'h5E; exp_tag[wr_p+1] = "R1";
      wr_p += 2;
    end else if (b == 8'h7D) begin
      exp_b[wr_p] = 8'h7D; exp_tag[wr_p] = "R2";
      exp_b[wr_p+1] = 8'h5D; exp_tag[wr_p+1] = "R2";
      wr_p += 2;
    end else begin
      exp_b[wr_p] = b; exp_tag[wr_p] = "R3";
      wr_p += 1;
    end
  endfunction

  function automatic logic [7:0] next_rand_byte();
    dat_lfsr = {dat_lfsr[14:0], dat_lfsr[15] ^ dat_lfsr[13] ^ dat_lfsr[12] ^ dat_lfsr[10]};
    case (dat_lfsr[2:0])
      3'd0, 3'd5: return 8'h7E;
      3'd1:       return 8'h7D;
      default:    return dat_lfsr[15:8];
    endcase
  endfunction

  // out_ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'b0;
        default: begin
          rdy_lfsr  = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
          out_ready = rdy_lfsr[0] | rdy_lfsr[3];
        end
      endcase
    end
  end

  // output monitor
  bit          held = 0;
  logic [31:0] h_data;
  logic [2:0]  h_bytes;
  logic        h_eof;
  initial begin
    int mis, idx;
    bit exp_sof, exp_eof;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (held)
          check(out_valid && out_data == h_data && out_bytes == h_bytes && out_eof == h_eof,
                "R9", "held word", out_data, h_data);
        held    = out_valid && !out_ready;
        h_data  = out_data;
        h_bytes = out_bytes;
        h_eof   = out_eof;
        if (out_valid && out_ready) begin
          mis = -1;
          for (int b = 0; b < int'(out_bytes); b++)
            if (mis < 0 && (rd_p + b >= wr_p || out_data[b*8 +: 8] !== exp_b[rd_p + b])) mis = b;
          if (mis < 0) check(1'b1, "R3", "word", 0, 0);
          else begin
            idx = rd_p + mis;
            if (idx >= wr_p) check(1'b0, "R6", "extra byte", out_data[mis*8 +: 8], 0);
            else check(1'b0, exp_tag[idx], "byte", out_data[mis*8 +: 8], exp_b[idx]);
          end
          exp_sof = (fr_rd < fr_wr) && (rd_p == fr_start[fr_rd]);
          exp_eof = (fr_rd < fr_wr) && (rd_p + int'(out_bytes) == fr_end[fr_rd]);
          check(out_sof == exp_sof, "R7", "sof flag", out_sof, exp_sof);
          check(out_eof == exp_eof, "R6", "eof flag", out_eof, exp_eof);
          if (!exp_eof) check(out_bytes == 3'd4, "R4", "dense word bytes", out_bytes, 4);
          else check((out_data >> (int'(out_bytes) * 8)) == 32'h0, "R6", "pad lanes", out_data, 0);
          rd_p += int'(out_bytes);
          if (out_eof) fr_rd++;
        end
      end
    end
  end

  task automatic send_frame(input int n, input bit junk);
    int nw, nb;
    fr_start[fr_wr] = wr_p;
    for (int i = 0; i < n; i++) model_byte(src_b[i]);
    fr_end[fr_wr] = wr_p;
    fr_wr++;
    acc_cyc = 0;
    nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      @(posedge clk); #1;
      nb = (n - 4 * w > 4) ? 4 : n - 4 * w;
      in_valid = 1'b1;
      in_sof   = (w == 0);
      in_eof   = (w == nw - 1);
      in_bytes = 3'(nb);
      for (int l = 0; l < 4; l++)
        in_data[l*8 +: 8] = (l < nb) ? src_b[4*w + l] : (junk ? 8'h7E : 8'h00);
      forever begin
        @(negedge clk);
        acc_cyc++;
        if (in_ready) break;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0; in_bytes = 3'd4;
  endtask

  task automatic wait_drain();
    while (rd_p != wr_p || fr_rd != fr_wr) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!out_valid, "R6", "no word after frame end", out_valid, 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after reset", {in_ready, out_valid}, 2);
  endtask

  task automatic t_plain();
    ready_mode = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) src_b[i] = 8'(8'h10 + i);
    send_frame(32, 0);
    check(acc_cyc == 8, "R5", "plain accept cycles", acc_cyc, 8);
    wait_drain();
  endtask

  task automatic t_examples();
    ready_mode = 0;
    src_b[0] = 8'h6C; src_b[1] = 8'h12; src_b[2] = 8'h7E; src_b[3] = 8'h51; src_b[4] = 8'h4A;
    send_frame(5, 0);
    src_b[0] = 8'hA1; src_b[1] = 8'h7E; src_b[2] = 8'h12; src_b[3] = 8'h8C; src_b[4] = 8'h55;
    send_frame(5, 0);
    wait_drain();
  endtask

  task automatic t_esc_esc();
    ready_mode = 0;
    src_b[0] = 8'h7D; src_b[1] = 8'h00; src_b[2] = 8'h7D; src_b[3] = 8'h7D;
    src_b[4] = 8'h20; src_b[5] = 8'h5D; src_b[6] = 8'h7D;
    send_frame(7, 0);
    wait_drain();
  endtask

  task automatic t_worst();
    ready_mode = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) src_b[i] = 8'h7E;
    send_frame(32, 0);
    check(acc_cyc == 15, "R5", "all-flag accept cycles", acc_cyc, 15);
    wait_drain();
  endtask

  task automatic t_short();
    ready_mode = 2;
    for (int n = 1; n <= 7; n++) begin
      for (int i = 0; i < n; i++) src_b[i] = (i == 2) ? 8'h7E : 8'(8'h40 + i + n);
      send_frame(n, 1);  // R11: junk 0x7E in unused lanes
    end
    wait_drain();
    check(rd_p == wr_p, "R11", "total bytes after short words", rd_p, wr_p);
  endtask

  task automatic t_eof_block();
    bit blocked;
    ready_mode = 1;
    repeat (3) @(negedge clk);
    src_b[0] = 8'h01; src_b[1] = 8'h7E; src_b[2] = 8'h03; src_b[3] = 8'h04;
    send_frame(4, 0);
    blocked = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (in_ready) blocked = 0;
    end
    check(blocked, "R8", "in_ready low while frame tail waits", !blocked, 0);
    ready_mode = 0;
    wait_drain();
    check(in_ready == 1'b1, "R8", "in_ready back after tail", in_ready, 1);
  endtask

  task automatic t_random();
    int lens [4] = '{13, 20, 4, 9};
    ready_mode = 2;
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < lens[f]; i++) src_b[i] = next_rand_byte();
      send_frame(lens[f], f[0]);
    end
    ready_mode = 0;
    wait_drain();
    check(rd_p == wr_p, "R3", "all random bytes delivered", rd_p, wr_p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_examples();
    t_esc_esc();
    t_worst();
    t_short();
    t_eof_block();
    t_random();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule